// File: doc/BRIEF.md
# UART FIFO Control and Buffers

This block holds the write-only FIFO control register of a UART together with the two 16-entry byte queues it governs. The receive queue is filled by the receive shift register and drained by the host. The transmit queue is filled by the host and drained by the serializer. A host control write can do four things: enable both queues, flush either queue, pick one of two DMA signalling modes, and choose the receive trigger threshold from a 2-bit code.

The block reports the following:
- the occupancy of each queue, with its full and empty flags;
- the stored control fields;
- a receive-threshold interrupt that stays high while the receive occupancy is at or above the selected threshold;
- a one-cycle overrun pulse when a byte arrives at a full receive queue.

The control fields change only on a write that also sets the enable bit. Flush commands act once and are never stored. The shift registers themselves lie outside this block.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the enable bit, the DMA mode and the trigger code are 0. Both counts are 0, both empty flags are 1, and `rx_irq` and `rx_overrun` are 0.
- R2: A control write always loads the enable bit from bit 0. It loads the DMA mode from bit 3 and the trigger code from bits 7:6 only when bit 0 of the same write is 1. Otherwise those two fields keep their values.
- R3: A control write with bits 0 and 1 both set empties the receive queue: `rx_count` is 0 after that edge, and the transmit queue is left unchanged. Bit 1 of `ctl_value` always reads 0.
- R4: A control write with bits 0 and 2 both set empties the transmit queue: `tx_count` is 0 after that edge, and the receive queue is left unchanged. Bit 2 of `ctl_value` always reads 0.
- R5: Write bits 5:4 are ignored. `ctl_value` is {trigger code[7:6], 2'b00, DMA mode[3], 2'b00, enable[0]}.
- R6: Each queue holds up to 16 bytes and returns them in the order written. The read data shows the oldest byte before it is popped. Each accepted push or pop changes the count by one at the clock edge that accepts it.
- R7: Trigger codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 bytes. `rx_irq` is 1 exactly when the queues are enabled and `rx_count` is at or above the threshold, so it asserts the cycle the count equals the threshold.
- R8: A receive queue that has reached its threshold keeps accepting bytes until it holds 16. A push and a pop in the same cycle on a full queue are both accepted.
- R9: A receive push into a full queue (with no pop in the same cycle) is dropped, and `rx_overrun` is 1 for exactly the following cycle. A transmit push into a full queue is dropped silently.
- R10: While the enable bit is 0, pushes and pops on both queues are ignored.
- R11: A pop on an empty queue is ignored and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data |
| ctl_value | output | 8 | Stored control fields |
| fifo_en | output | 1 | Queues enabled |
| dma_mode | output | 1 | Selected DMA signalling mode |
| rx_push | input | 1 | Byte from receive shift register |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads receive queue |
| rx_rdata | output | 8 | Oldest received byte |
| rx_count | output | 5 | Receive occupancy 0..16 |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_irq | output | 1 | Receive threshold reached |
| rx_overrun | output | 1 | One-cycle overrun pulse |
| tx_push | input | 1 | Host writes transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_rdata | output | 8 | Oldest byte to transmit |
| tx_count | output | 5 | Transmit occupancy 0..16 |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
For each of the four trigger codes, the receive queue is filled one byte at a time from empty to full and then drained. This places the interrupt edge at each of 1, 4, 8 and 14 and separates a threshold test using "equal" or "greater" from one using "at or above". Every byte carries a value unique to its code and position, so a lost, repeated or reordered byte shows up as a data mismatch rather than only as a count error. Pushing into a full queue, pushing and popping a full queue together, and popping an empty queue tell overrun handling apart from ordinary full behaviour. Flushes are issued with both queues partly filled, so a flush that hits the wrong queue is caught, and writes with the enable bit clear show that the fields are held and that traffic is ignored.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [7:0]                   cfg_wdata,
  output logic [7:0]                   ctl_value,
  output logic                         fifo_en,
  output logic                         dma_mode,
  input  logic                         rx_push,
  input  logic [DW-1:0]                rx_wdata,
  input  logic                         rx_pop,
  output logic [DW-1:0]                rx_rdata,
  output logic [$clog2(DEPTH):0]       rx_count,
  output logic                         rx_full,
  output logic                         rx_empty,
  output logic                         rx_irq,
  output logic                         rx_overrun,
  input  logic                         tx_push,
  input  logic [DW-1:0]                tx_wdata,
  input  logic                         tx_pop,
  output logic [DW-1:0]                tx_rdata,
  output logic [$clog2(DEPTH):0]       tx_count,
  output logic                         tx_full,
  output logic                         tx_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic       en_q, dma_q;
  logic [1:0] trig_q;

  wire cfg_go = cfg_we && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= 2'b00;
    end else if (cfg_we) begin
      en_q <= cfg_wdata[0];
      if (cfg_wdata[0]) begin
        dma_q  <= cfg_wdata[3];
        trig_q <= cfg_wdata[7:6];
      end
    end
  end

  assign ctl_value = {trig_q, 2'b00, dma_q, 2'b00, en_q};
  assign fifo_en   = en_q;
  assign dma_mode  = dma_q;

  logic [1:0]    flush_c, push_c, pop_c;
  logic [DW-1:0] wd_c [2];
  logic [DW-1:0] rd_c [2];
  logic [CW-1:0] cnt_c [2];

  assign flush_c = {cfg_go && cfg_wdata[2], cfg_go && cfg_wdata[1]};
  assign push_c  = {tx_push, rx_push};
  assign pop_c   = {tx_pop, rx_pop};
  assign wd_c[0] = rx_wdata;
  assign wd_c[1] = tx_wdata;

  for (genvar c = 0; c < 2; c++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    wire is_full  = (cnt == CW'(DEPTH));
    wire is_empty = (cnt == '0);
    wire do_pop   = en_q && pop_c[c] && !is_empty && !flush_c[c];
    wire do_push  = en_q && push_c[c] && (!is_full || do_pop) && !flush_c[c];

    always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wd_c[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (flush_c[c]) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= wp + AW'(1);
        if (do_pop)  rp <= rp + AW'(1);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end

    assign cnt_c[c] = cnt;
    assign rd_c[c]  = mem[rp];
  end

  assign rx_count = cnt_c[0];
  assign tx_count = cnt_c[1];
  assign rx_rdata = rd_c[0];
  assign tx_rdata = rd_c[1];
  assign rx_full  = (rx_count == CW'(DEPTH));
  assign rx_empty = (rx_count == '0);
  assign tx_full  = (tx_count == CW'(DEPTH));
  assign tx_empty = (tx_count == '0);

  function automatic logic [CW-1:0] level_of(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(1);
      2'd1:    return CW'(4);
      2'd2:    return CW'(8);
      default: return CW'(14);
    endcase
  endfunction

  assign rx_irq = en_q && (rx_count >= level_of(trig_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_overrun <= 1'b0;
    else        rx_overrun <= en_q && rx_push && rx_full && !rx_pop && !flush_c[0];
  end

  a_r2_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[0] |=> dma_mode == $past(dma_mode) && ctl_value[7:6] == $past(ctl_value[7:6]));

  a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[0] && cfg_wdata[1] |=> rx_count == '0);

  a_r4_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[0] && cfg_wdata[2] |=> tx_count == '0);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH) && tx_count <= CW'(DEPTH));

  a_r9_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_full && $past(rx_full));

  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && !cfg_we |=> rx_count == $past(rx_count) && tx_count == $past(tx_count));
endmodule

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_wdata = 0, tx_wdata = 0;
  logic [7:0] ctl_value, rx_rdata, tx_rdata;
  logic       fifo_en, dma_mode, rx_full, rx_empty, rx_irq, rx_overrun, tx_full, tx_empty;
  logic [4:0] rx_count, tx_count;
  int checks = 0, fails = 0;
  bit done = 0;
  int lv [4] = '{1, 4, 8, 14};

  always #2 clk = ~clk;

  uart_fifo_ctl u_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctl_value(ctl_value), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty), .rx_irq(rx_irq),
    .rx_overrun(rx_overrun), .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(logic [7:0] w);
    cfg_we = 1; cfg_wdata = w; tick(); cfg_we = 0;
  endtask

  task automatic prx(logic [7:0] d);
    rx_push = 1; rx_wdata = d; tick(); rx_push = 0;
  endtask

  task automatic ptx(logic [7:0] d);
    tx_push = 1; tx_wdata = d; tick(); tx_push = 0;
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 ctl", ctl_value, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 empties", {rx_empty, tx_empty}, 3);
    chk("R1 irq/ovr", {rx_irq, rx_overrun}, 0);

    cfg(8'hF9);
    chk("R5 ctl readback", ctl_value, 8'hC9);
    chk("R2 dma loaded", dma_mode, 1);
    cfg(8'h00);
    chk("R2 fields held", ctl_value, 8'hC8);
    chk("R2 enable cleared", fifo_en, 0);
    cfg(8'h36);
    chk("R2 no load w/o enable", ctl_value, 8'hC8);

    prx(8'h11); ptx(8'h22);
    chk("R10 rx ignored", rx_count, 0);
    chk("R10 tx ignored", tx_count, 0);
    rx_pop = 1; tick(); rx_pop = 0;
    chk("R10 irq off", rx_irq, 0);

    for (int code = 0; code < 4; code++) begin
      cfg(8'((code << 6) | 8'h07));
      chk("R3 ctl self-clear", ctl_value, (code << 6) | 1);
      chk("R3 rx empty", rx_count, 0);
      for (int k = 1; k <= 16; k++) begin
        prx(8'(code * 16 + k));
        chk("R6 count", rx_count, k);
        chk("R7 irq", rx_irq, int'(k >= lv[code]));
        chk("R8 full", rx_full, int'(k == 16));
      end
      prx(8'hFF);
      chk("R9 overrun pulse", rx_overrun, 1);
      chk("R9 count kept", rx_count, 16);
      tick();
      chk("R9 pulse ends", rx_overrun, 0);
      for (int k = 0; k < 16; k++) begin
        chk("R6 order", rx_rdata, code * 16 + k + 1);
        rx_pop = 1; tick(); rx_pop = 0;
        chk("R6 pop count", rx_count, 15 - k);
        chk("R7 irq drain", rx_irq, int'(15 - k >= lv[code]));
      end
      rx_pop = 1; tick(); rx_pop = 0;
      chk("R11 pop empty", rx_count, 0);
    end

    for (int k = 0; k < 16; k++) prx(8'(k + 100));
    rx_push = 1; rx_pop = 1; rx_wdata = 8'd200; tick(); rx_push = 0; rx_pop = 0;
    chk("R8 push+pop full count", rx_count, 16);
    chk("R8 no overrun", rx_overrun, 0);
    chk("R8 head advanced", rx_rdata, 101);
    cfg(8'h03);

    for (int k = 0; k < 16; k++) ptx(8'(k * 3));
    chk("R6 tx full", tx_full, 1);
    ptx(8'hEE);
    chk("R9 tx drop count", tx_count, 16);
    chk("R9 tx no overrun", rx_overrun, 0);
    for (int k = 0; k < 16; k++) begin
      chk("R6 tx order", tx_rdata, k * 3);
      tx_pop = 1; tick(); tx_pop = 0;
    end
    tx_pop = 1; tick(); tx_pop = 0;
    chk("R11 tx pop empty", tx_count, 0);

    prx(8'd1); prx(8'd2); prx(8'd3);
    ptx(8'd9); ptx(8'd8);
    cfg(8'h05);
    chk("R4 tx flushed", tx_count, 0);
    chk("R4 rx kept", rx_count, 3);
    chk("R4 ctl self-clear", ctl_value, 1);
    ptx(8'd7);
    cfg(8'h03);
    chk("R3 rx flushed", rx_count, 0);
    chk("R3 tx kept", tx_count, 1);
    chk("R3 tx data kept", tx_rdata, 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule